// File: doc/BRIEF.md
# Split-Transaction OUT Chunk Sequencer

This block cuts one full-speed OUT payload, which travels through a high-speed hub, into a run of start-split chunks. Software hands it the total byte count together with a starting two-bit position tag and the number of start-splits it expects. The block checks that these three values agree with one another. It then presents one chunk at a time, giving its byte length, its position tag and the number of chunks still to go. A one-cycle acknowledge from the packet builder retires the chunk that is showing.

Every chunk holds up to 188 bytes. All chunks except the final one are full. The position tag and the remaining count are kept by the block from the first chunk to the last. A load whose values disagree raises an error flag and issues nothing. When the last chunk is acknowledged, the block signals completion with a single-cycle pulse.

Top module: `split_out_seq`

## Requirements
- R1: After reset, chunk_valid_o, done_o and err_o are 0, and cnt_left_o, chunk_len_o and pos_o are all 0.
- R2: A load taken while idle is accepted when four conditions hold: init_cnt_i lies in 1..6, it equals ceil(total_len_i/188), and init_pos_i is 00 when the count is 1 and 01 when it is larger. One cycle after the load, chunk_valid_o is 1, pos_o equals init_pos_i and cnt_left_o equals init_cnt_i.
- R3: For an n-chunk transfer, chunk_len_o is 188 on chunks 1..n-1 and total_len_i-188*(n-1) on the last chunk. It is never 0 while chunk_valid_o is 1, and it reads 0 while idle.
- R4: The position tags are 00 for a payload sent whole, 01 for the first chunk, 10 for a middle chunk and 11 for the final chunk. After an acknowledge the tag becomes 11 if the count before it was 2, and 10 if it was above 2.
- R5: Each acknowledge of a valid chunk lowers cnt_left_o by exactly one, one cycle later. cnt_left_o never exceeds 6.
- R6: An idle load raises err_o one cycle later and leaves chunk_valid_o at 0 if any of these holds: the count is above 6, the count is 0, the count differs from ceil(length/188), or the starting tag does not match the count. err_o then stays at 1 until a valid idle load clears it.
- R7: The acknowledge of the last chunk drops chunk_valid_o and sets cnt_left_o to 0 one cycle later. In that same cycle done_o is 1, and it is 0 on the following cycle.
- R8: A load asserted while a transfer is in progress has no effect on pos_o, cnt_left_o, chunk_len_o or err_o.
- R9: An acknowledge while no chunk is valid has no effect. chunk_valid_o, done_o and cnt_left_o keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Start a transfer with the values below |
| total_len_i | input | 11 | Payload length in bytes |
| init_pos_i | input | 2 | Software-set starting position tag |
| init_cnt_i | input | 3 | Software-set number of start-splits |
| issue_ack_i | input | 1 | The current chunk has been issued |
| chunk_valid_o | output | 1 | A chunk is being presented |
| chunk_len_o | output | 11 | Byte length of the current chunk |
| pos_o | output | 2 | Position tag of the current chunk |
| cnt_left_o | output | 3 | Chunks remaining, including the current one |
| err_o | output | 1 | The last idle load was rejected |
| done_o | output | 1 | One-cycle pulse after the last chunk |

## Verification
The bench runs payloads of several sizes. Lengths of exactly 188 and 189 bytes test the boundary between a whole payload and a Begin/End pair. Multi-chunk payloads with short final chunks show whether middle chunks are tagged Mid and whether the final length is computed correctly. Rejected loads cover each error cause separately (count too large, count mismatch, wrong starting tag, zero length), so each cause shows as its own failure. Directed runs keep the acknowledge high for many cycles, assert a load during an active transfer, and send an acknowledge while idle, to check that counting does not slip and that stray inputs change nothing.

// File: rtl/split_seq_pkg.sv
`timescale 1ns/1ps
package split_seq_pkg;

  typedef enum logic [1:0] {
    POS_ALL   = 2'b00,
    POS_BEGIN = 2'b01,
    POS_MID   = 2'b10,
    POS_END   = 2'b11
  } pos_e;

  // number of chunks of at most chunk bytes that a payload of len bytes needs
  function automatic int unsigned need_splits(input int unsigned len,
                                              input int unsigned chunk);
    return (len + chunk - 1) / chunk;
  endfunction

  // tag that the first chunk of an n-chunk transfer must carry
  function automatic pos_e first_pos(input int unsigned n);
    return (n == 1) ? POS_ALL : POS_BEGIN;
  endfunction

  // tag after retiring a chunk, given the count before the retirement
  function automatic pos_e next_pos(input int unsigned cnt_before);
    return (cnt_before == 2) ? POS_END : POS_MID;
  endfunction

  // bytes in the chunk cut from rem remaining bytes
  function automatic int unsigned piece_len(input int unsigned rem,
                                            input int unsigned chunk);
    return (rem > chunk) ? chunk : rem;
  endfunction

endpackage

// File: rtl/split_param_check.sv
`timescale 1ns/1ps
module split_param_check
  import split_seq_pkg::*;
#(
  parameter int unsigned CHUNK   = 188,
  parameter int unsigned MAX_CNT = 6,
  parameter int unsigned LEN_W   = 11,
  parameter int unsigned CNT_W   = 3
) (
  input  logic [LEN_W-1:0] total_len_i,
  input  logic [1:0]       init_pos_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  output logic             params_ok_o
);

  logic        cnt_over;
  logic        cnt_zero;
  logic        cnt_mismatch;
  logic        pos_mismatch;
  int unsigned need;

  always_comb begin
    need         = need_splits(32'(total_len_i), CHUNK);
    cnt_over     = 32'(init_cnt_i) > MAX_CNT;
    cnt_zero     = init_cnt_i == '0;
    cnt_mismatch = 32'(init_cnt_i) != need;
    pos_mismatch = init_pos_i != first_pos(32'(init_cnt_i));
    params_ok_o  = !(cnt_over || cnt_zero || cnt_mismatch || pos_mismatch);
  end

endmodule

// File: rtl/split_byte_track.sv
`timescale 1ns/1ps
module split_byte_track
  import split_seq_pkg::*;
#(
  parameter int unsigned CHUNK = 188,
  parameter int unsigned LEN_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic             advance_i,
  output logic [LEN_W-1:0] chunk_len_o
);

  logic [LEN_W-1:0] rem_q;

  assign chunk_len_o = LEN_W'(piece_len(32'(rem_q), CHUNK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
    end else if (start_i) begin
      rem_q <= total_len_i;
    end else if (advance_i) begin
      rem_q <= rem_q - chunk_len_o;
    end
  end

  AST_REM_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    advance_i |=> (rem_q < $past(rem_q))); // R3

endmodule

// File: rtl/split_pos_track.sv
`timescale 1ns/1ps
module split_pos_track
  import split_seq_pkg::*;
#(
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       init_pos_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic             advance_i,
  output logic             active_o,
  output logic [1:0]       pos_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);

  logic             active_q;
  logic [1:0]       pos_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;
  logic             last_ack;

  assign last_ack = advance_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      cnt_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= last_ack;
      if (start_i) begin
        active_q <= 1'b1;
        pos_q    <= init_pos_i;
        cnt_q    <= init_cnt_i;
      end else if (advance_i) begin
        cnt_q <= cnt_q - CNT_W'(1);
        if (last_ack) active_q <= 1'b0;
        else          pos_q    <= next_pos(32'(cnt_q));
      end
    end
  end

  assign active_o = active_q;
  assign pos_o    = pos_q;
  assign cnt_o    = cnt_q;
  assign done_o   = done_q;

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1))); // R5
  AST_END_IS_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && pos_q == POS_END) |-> (cnt_q == CNT_W'(1))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!active_q && cnt_q == '0)); // R7
  AST_IDLE_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    !active_q |-> (cnt_q == '0 || start_i == 1'b0)); // R9

endmodule

// File: rtl/split_out_seq.sv
`timescale 1ns/1ps
module split_out_seq
  import split_seq_pkg::*;
#(
  parameter  int unsigned CHUNK   = 188,
  parameter  int unsigned MAX_CNT = 6,
  localparam int unsigned CNT_W   = $clog2(MAX_CNT + 2),
  localparam int unsigned LEN_W   = $clog2(MAX_CNT * CHUNK + 2)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [LEN_W-1:0] total_len_i,
  input  logic [1:0]       init_pos_i,
  input  logic [CNT_W-1:0] init_cnt_i,
  input  logic             issue_ack_i,
  output logic             chunk_valid_o,
  output logic [LEN_W-1:0] chunk_len_o,
  output logic [1:0]       pos_o,
  output logic [CNT_W-1:0] cnt_left_o,
  output logic             err_o,
  output logic             done_o
);

  logic             params_ok;
  logic             active;
  logic             start;
  logic             advance;
  logic             idle_load;
  logic [LEN_W-1:0] chunk_len;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       pos;
  logic             done;
  logic             err_q;

  assign idle_load = load_i && !active;
  assign start     = idle_load && params_ok;
  assign advance   = active && issue_ack_i;

  split_param_check #(
    .CHUNK(CHUNK), .MAX_CNT(MAX_CNT), .LEN_W(LEN_W), .CNT_W(CNT_W)
  ) u_check (
    .total_len_i(total_len_i),
    .init_pos_i (init_pos_i),
    .init_cnt_i (init_cnt_i),
    .params_ok_o(params_ok)
  );

  split_byte_track #(.CHUNK(CHUNK), .LEN_W(LEN_W)) u_bytes (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .total_len_i(total_len_i),
    .advance_i  (advance),
    .chunk_len_o(chunk_len)
  );

  split_pos_track #(.CNT_W(CNT_W)) u_pos (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .init_pos_i(init_pos_i),
    .init_cnt_i(init_cnt_i),
    .advance_i (advance),
    .active_o  (active),
    .pos_o     (pos),
    .cnt_o     (cnt),
    .done_o    (done)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)         err_q <= 1'b0;
    else if (idle_load) err_q <= !params_ok;
  end

  assign chunk_valid_o = active;
  assign chunk_len_o   = active ? chunk_len : '0;
  assign pos_o         = pos;
  assign cnt_left_o    = cnt;
  assign err_o         = err_q;
  assign done_o        = done;

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !active); // R6
  AST_FULL_NONLAST: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cnt > CNT_W'(1)) |-> (chunk_len == LEN_W'(CHUNK))); // R3
  AST_CHUNK_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (chunk_len != '0)); // R3
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= MAX_CNT); // R5
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(active && issue_ack_i)); // R7
  AST_BUSY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (active && load_i && !issue_ack_i) |=> ($stable(cnt) && $stable(pos) && $stable(err_q))); // R8

endmodule

// File: tb/test_split_out_seq.sv
`timescale 1ns/1ps
module test_split_out_seq;

  localparam int CH = 188;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_i = 1'b0;
  logic [10:0] total_len_i = '0;
  logic [1:0]  init_pos_i = '0;
  logic [2:0]  init_cnt_i = '0;
  logic        issue_ack_i = 1'b0;
  logic        chunk_valid_o;
  logic [10:0] chunk_len_o;
  logic [1:0]  pos_o;
  logic [2:0]  cnt_left_o;
  logic        err_o;
  logic        done_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  split_out_seq i_split_out_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .total_len_i(total_len_i),
    .init_pos_i(init_pos_i), .init_cnt_i(init_cnt_i), .issue_ack_i(issue_ack_i),
    .chunk_valid_o(chunk_valid_o), .chunk_len_o(chunk_len_o), .pos_o(pos_o),
    .cnt_left_o(cnt_left_o), .err_o(err_o), .done_o(done_o)
  );

  // {len[10:0], pos[1:0], cnt[2:0], expect_err}
  localparam logic [16:0] VEC [13] = '{
    {11'd100,  2'b00, 3'd1, 1'b0},
    {11'd188,  2'b00, 3'd1, 1'b0},
    {11'd189,  2'b01, 3'd2, 1'b0},
    {11'd376,  2'b01, 3'd2, 1'b0},
    {11'd600,  2'b01, 3'd4, 1'b0},
    {11'd1128, 2'b01, 3'd6, 1'b0},
    {11'd1129, 2'b01, 3'd7, 1'b1},
    {11'd500,  2'b01, 3'd2, 1'b1},
    {11'd100,  2'b01, 3'd1, 1'b1},
    {11'd0,    2'b00, 3'd0, 1'b1},
    {11'd400,  2'b00, 3'd3, 1'b1},
    {11'd1000, 2'b01, 3'd6, 1'b0},
    {11'd700,  2'b01, 3'd3, 1'b1}
  };

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_load(input int len, input int pos, input int cnt);
    @(negedge clk);
    total_len_i = 11'(len);
    init_pos_i  = 2'(pos);
    init_cnt_i  = 3'(cnt);
    load_i      = 1'b1;
    @(negedge clk);
    load_i      = 1'b0;
  endtask

  task automatic pulse_ack();
    issue_ack_i = 1'b1;
    @(negedge clk);
    issue_ack_i = 1'b0;
  endtask

  function automatic int count_chunks(input int len);
    int n = 0;
    int r = len;
    while (r > 0) begin
      n++;
      r = (r > CH) ? r - CH : 0;
    end
    return n;
  endfunction

  function automatic int tag_for(input int i, input int n);
    if (n == 1) return 0;
    if (i == 0) return 1;
    if (i == n - 1) return 3;
    return 2;
  endfunction

  task automatic run_vec(input int len, input int pos, input int cnt, input bit bad);
    int n;
    do_load(len, pos, cnt);
    if (bad) begin
      check_eq("R6 err raised", err_o, 1);
      check_eq("R6 no chunk", chunk_valid_o, 0);
      return;
    end
    n = count_chunks(len);
    check_eq("R2 err clear", err_o, 0);
    check_eq("R2 chunk valid", chunk_valid_o, 1);
    for (int i = 0; i < n; i++) begin
      check_eq("R3 chunk length", chunk_len_o, (i < n - 1) ? CH : len - CH * (n - 1));
      check_eq("R4 position tag", pos_o, tag_for(i, n));
      check_eq("R5 remaining count", cnt_left_o, n - i);
      pulse_ack();
    end
    check_eq("R7 done pulse", done_o, 1);
    check_eq("R7 valid dropped", chunk_valid_o, 0);
    check_eq("R7 count zero", cnt_left_o, 0);
    check_eq("R3 idle length", chunk_len_o, 0);
    @(negedge clk);
    check_eq("R7 done one cycle", done_o, 0);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog all actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check_eq("R1 valid", chunk_valid_o, 0);
    check_eq("R1 done", done_o, 0);
    check_eq("R1 err", err_o, 0);
    check_eq("R1 count", cnt_left_o, 0);
    check_eq("R1 length", chunk_len_o, 0);
    check_eq("R1 tag", pos_o, 0);

    for (int v = 0; v < 13; v++)
      run_vec(int'(VEC[v][16:6]), int'(VEC[v][5:4]), int'(VEC[v][3:1]), VEC[v][0]);

    // R6 error persists over idle cycles and stray acks, then cleared by a good load
    do_load(500, 1, 2);
    repeat (3) @(negedge clk);
    pulse_ack();
    check_eq("R6 err held", err_o, 1);
    check_eq("R6 still no chunk", chunk_valid_o, 0);
    do_load(300, 1, 2);
    check_eq("R6 err cleared", err_o, 0);
    check_eq("R2 valid after clear", chunk_valid_o, 1);
    pulse_ack();
    pulse_ack();
    check_eq("R7 done after two", done_o, 1);

    // R8 load during a transfer is ignored
    do_load(600, 1, 4);
    pulse_ack();
    do_load(100, 0, 1);
    check_eq("R8 tag kept", pos_o, 2);
    check_eq("R8 count kept", cnt_left_o, 3);
    check_eq("R8 length kept", chunk_len_o, CH);
    check_eq("R8 err kept", err_o, 0);
    do_load(1129, 1, 7);
    check_eq("R8 bad load ignored", err_o, 0);

    // back-to-back acks: R5 count drops each cycle, R4 end tag, R7 done
    issue_ack_i = 1'b1;
    @(negedge clk);
    check_eq("R5 b2b count", cnt_left_o, 2);
    check_eq("R4 b2b tag mid", pos_o, 2);
    @(negedge clk);
    check_eq("R4 b2b tag end", pos_o, 3);
    check_eq("R3 b2b last len", chunk_len_o, 600 - 3 * CH);
    @(negedge clk);
    check_eq("R7 b2b done", done_o, 1);
    @(negedge clk);
    issue_ack_i = 1'b0;
    // R9 ack held while idle changes nothing
    check_eq("R9 valid", chunk_valid_o, 0);
    check_eq("R9 done", done_o, 0);
    check_eq("R9 count", cnt_left_o, 0);
    pulse_ack();
    check_eq("R9 single ack idle", cnt_left_o, 0);
    check_eq("R9 no done", done_o, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule